// File: doc/BRIEF.md
# Mutual Authentication Protocol Sequencer

This block is the gatekeeper in front of a chip's protected function logic. It runs a two-way challenge–response exchange with a removable token over a plain word-stream link. Nothing downstream starts until the exchange completes. The sequencer does no arithmetic itself. It drives request/acknowledge ports on three neighbouring engines: a modular-exponentiation engine that selects its key pair from a one-bit key selector, a random source, and a hash engine. It then sequences their results.

A run has two phases. In the first, the chip proves itself. It decrypts the token's challenge with the token's public key, re-encrypts the result under its own private key and returns it. Once the token accepts that reply, the second phase begins and the token proves itself. The chip draws a fresh nonce, encrypts it and sends it out. It then takes the next word from the token, decrypts it and subtracts both nonces to recover the identity. It hashes the identity and looks the digest up in a small table of enrolled hashes, each entry carrying a valid bit. On a hit, the digest is forwarded as key-root material and the function enable is raised. It stays raised until the token is withdrawn.

Top module: `auth_seq`

## Requirements
- R1: After reset, and whenever no run is active, `func_en`, `tx_valid`, `auth_fail` and all engine requests are low. Words on the receive link are ignored. A run starts only on a low-to-high transition of `card_present`.
- R2: The first received word of a run is sent to the exponentiation engine as `exp_base` with `exp_key_sel` = 0 (token public key). The result is kept as the token nonce.
- R3: The kept token nonce is sent to the exponentiation engine with `exp_key_sel` = 1 (chip private key). The result is emitted as a single-cycle `tx_valid` word.
- R4: After `tok_accept`, exactly one nonce is requested from the random source. It is encrypted with `exp_key_sel` = 1 and emitted as the next `tx_valid` word.
- R5: The next received word is decrypted with `exp_key_sel` = 0. `hash_msg` equals that result minus the token nonce minus the chip nonce, modulo 2^W.
- R6: If the returned digest equals a valid table entry, `func_en` rises, `key_root` carries that digest, and no engine request is raised while `func_en` is high.
- R7: If no valid entry matches, `auth_fail` pulses for exactly one cycle, `func_en` stays low and the unit returns to idle.
- R8: An entry whose valid bit is 0 never matches, even when its stored hash equals the digest.
- R9: Every run draws a new nonce, so a receive word replayed from an earlier run recovers a different identity and is rejected.
- R10: Withdrawing the token in any state returns the unit to idle with `func_en` low and no `auth_fail` pulse. This takes priority over an engine completion in the same cycle. `tok_reject` during a run returns to idle with an `auth_fail` pulse.
- R11: If any waiting state is held for TIMEOUT cycles, the run is rejected with an `auth_fail` pulse.
- R12: Table writes take effect only while the unit is idle. A write issued at any other time leaves the table unchanged.
- R13: An engine request stays high until its ready is seen. At most one of the three requests is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Token inserted |
| rx_valid | input | 1 | Received word strobe |
| rx_data | input | W | Received word |
| tok_accept | input | 1 | Token accepted the chip's reply |
| tok_reject | input | 1 | Token refused; abort the run |
| tx_valid | output | 1 | Word to token, one cycle |
| tx_data | output | W | Word to token |
| exp_req | output | 1 | Exponentiation request |
| exp_rdy | input | 1 | Exponentiation engine accepts request |
| exp_key_sel | output | 1 | 0 = token public key, 1 = chip private key |
| exp_base | output | W | Exponentiation operand |
| exp_done | input | 1 | Exponentiation result strobe |
| exp_result | input | W | Exponentiation result |
| rng_req | output | 1 | Nonce request |
| rng_rdy | input | 1 | Random source accepts request |
| rng_done | input | 1 | Nonce strobe |
| rng_data | input | W | Nonce |
| hash_req | output | 1 | Hash request |
| hash_rdy | input | 1 | Hash engine accepts request |
| hash_msg | output | W | Recovered identity to hash |
| hash_done | input | 1 | Digest strobe |
| hash_digest | input | HASH_W | Digest |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_hash | input | HASH_W | Hash to store |
| tbl_valid | input | 1 | Valid bit to store |
| func_en | output | 1 | Protected logic enable |
| key_root | output | HASH_W | Matched digest for the cipher unit |
| auth_fail | output | 1 | Rejection pulse |

## Verification
Two events can land in the same cycle: the token is withdrawn exactly as the hash engine signals completion, or a table write arrives while the enable is high. The bench's hash model drops `card_present` on the very cycle it raises `hash_done`. The run must then end with neither an enable nor a rejection pulse. In the second case, an enrolled entry is invalidated while access is granted. A later run with the same identity must still be granted, which shows the write was discarded.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RX_CU, ST_DEC_CU, ST_ENC_MU, ST_VERIFY, ST_NONCE,
    ST_ENC_MF, ST_RX_CID, ST_DEC_CID, ST_HASH, ST_MATCH, ST_GRANT
  } auth_st_e;

  localparam logic KEY_TOKEN_PUB = 1'b0;
  localparam logic KEY_CHIP_PRIV = 1'b1;
endpackage

// File: rtl/auth_wait_timer.sv
module auth_wait_timer #(
  parameter int LIMIT = 64,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  // fires in the LIMIT-th cycle spent in one waiting state
  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/auth_hash_table.sv
module auth_hash_table #(
  parameter int HASH_W  = 160,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HASH_W-1:0] wr_hash,
  input  logic              wr_valid,
  input  logic [HASH_W-1:0] probe,
  output logic              hit
);
  logic [HASH_W-1:0]  ent [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (wr_en) ent[wr_idx] <= wr_hash;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_valid;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (ent[g] == probe);
  end

  assign hit = |match;
endmodule

// File: rtl/auth_seq.sv
module auth_seq
  import auth_seq_pkg::*;
#(
  parameter int W       = 32,
  parameter int HASH_W  = 160,
  parameter int ENTRIES = 4,
  parameter int TIMEOUT = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_present,
  input  logic              rx_valid,
  input  logic [W-1:0]      rx_data,
  input  logic              tok_accept,
  input  logic              tok_reject,
  output logic              tx_valid,
  output logic [W-1:0]      tx_data,
  output logic              exp_req,
  input  logic              exp_rdy,
  output logic              exp_key_sel,
  output logic [W-1:0]      exp_base,
  input  logic              exp_done,
  input  logic [W-1:0]      exp_result,
  output logic              rng_req,
  input  logic              rng_rdy,
  input  logic              rng_done,
  input  logic [W-1:0]      rng_data,
  output logic              hash_req,
  input  logic              hash_rdy,
  output logic [W-1:0]      hash_msg,
  input  logic              hash_done,
  input  logic [HASH_W-1:0] hash_digest,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [HASH_W-1:0] tbl_hash,
  input  logic              tbl_valid,
  output logic              func_en,
  output logic [HASH_W-1:0] key_root,
  output logic              auth_fail
);
  auth_st_e          st, st_nx;
  logic              card_q, issued, fail_nx;
  logic [W-1:0]      rx_word, mu, mf, id_rec;
  logic [HASH_W-1:0] digest;
  logic              eng_st, hs, fin, run, tmo, hit, tbl_wr_ok;

  assign eng_st = (st == ST_DEC_CU) || (st == ST_ENC_MU) ||
                  (st == ST_ENC_MF) || (st == ST_DEC_CID);

  // request ports are decoded from registered state only
  assign exp_req     = eng_st && !issued;
  assign rng_req     = (st == ST_NONCE) && !issued;
  assign hash_req    = (st == ST_HASH)  && !issued;
  assign exp_key_sel = ((st == ST_ENC_MU) || (st == ST_ENC_MF)) ? KEY_CHIP_PRIV : KEY_TOKEN_PUB;
  assign hash_msg    = id_rec;

  always_comb begin
    unique case (st)
      ST_ENC_MU: exp_base = mu;
      ST_ENC_MF: exp_base = mf;
      default:   exp_base = rx_word;
    endcase
  end

  assign hs  = (exp_req && exp_rdy) || (rng_req && rng_rdy) || (hash_req && hash_rdy);
  assign fin = issued && ((eng_st && exp_done) ||
                          ((st == ST_NONCE) && rng_done) ||
                          ((st == ST_HASH)  && hash_done));
  assign run = (st != ST_IDLE) && (st != ST_GRANT);

  auth_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .clr(st_nx != st), .run(run), .expired(tmo)
  );

  assign tbl_wr_ok = tbl_we && (st == ST_IDLE) && !func_en;

  auth_hash_table #(.HASH_W(HASH_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(tbl_wr_ok), .wr_idx(tbl_idx),
    .wr_hash(tbl_hash), .wr_valid(tbl_valid), .probe(digest), .hit(hit)
  );

  // priority: card withdrawal > token refusal / timeout > protocol progress
  always_comb begin
    st_nx   = st;
    fail_nx = 1'b0;
    if (st == ST_IDLE) begin
      if (card_present && !card_q) st_nx = ST_RX_CU;
    end else if (!card_present) begin
      st_nx = ST_IDLE;
    end else if (tok_reject || tmo) begin
      st_nx   = ST_IDLE;
      fail_nx = 1'b1;
    end else begin
      unique case (st)
        ST_RX_CU:   if (rx_valid)   st_nx = ST_DEC_CU;
        ST_DEC_CU:  if (fin)        st_nx = ST_ENC_MU;
        ST_ENC_MU:  if (fin)        st_nx = ST_VERIFY;
        ST_VERIFY:  if (tok_accept) st_nx = ST_NONCE;
        ST_NONCE:   if (fin)        st_nx = ST_ENC_MF;
        ST_ENC_MF:  if (fin)        st_nx = ST_RX_CID;
        ST_RX_CID:  if (rx_valid)   st_nx = ST_DEC_CID;
        ST_DEC_CID: if (fin)        st_nx = ST_HASH;
        ST_HASH:    if (fin)        st_nx = ST_MATCH;
        ST_MATCH: begin
          if (hit) st_nx = ST_GRANT;
          else begin
            st_nx   = ST_IDLE;
            fail_nx = 1'b1;
          end
        end
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      card_q    <= 1'b0;
      issued    <= 1'b0;
      auth_fail <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      func_en   <= 1'b0;
      key_root  <= '0;
      rx_word   <= '0;
      mu        <= '0;
      mf        <= '0;
      id_rec    <= '0;
      digest    <= '0;
    end else begin
      st        <= st_nx;
      card_q    <= card_present;
      auth_fail <= fail_nx;
      tx_valid  <= 1'b0;
      if (st_nx != st) issued <= 1'b0;
      else if (hs)     issued <= 1'b1;

      if (st == ST_RX_CU   && st_nx == ST_DEC_CU)  rx_word <= rx_data;
      if (st == ST_DEC_CU  && st_nx == ST_ENC_MU)  mu      <= exp_result;
      if (st == ST_ENC_MU  && st_nx == ST_VERIFY) begin
        tx_valid <= 1'b1;
        tx_data  <= exp_result;
      end
      if (st == ST_NONCE   && st_nx == ST_ENC_MF)  mf      <= rng_data;
      if (st == ST_ENC_MF  && st_nx == ST_RX_CID) begin
        tx_valid <= 1'b1;
        tx_data  <= exp_result;
      end
      if (st == ST_RX_CID  && st_nx == ST_DEC_CID) rx_word <= rx_data;
      if (st == ST_DEC_CID && st_nx == ST_HASH)    id_rec  <= exp_result - mu - mf;
      if (st == ST_HASH    && st_nx == ST_MATCH)   digest  <= hash_digest;
      if (st == ST_MATCH   && st_nx == ST_GRANT) begin
        func_en  <= 1'b1;
        key_root <= digest;
      end

      if (st_nx == ST_IDLE) begin
        func_en  <= 1'b0;
        key_root <= '0;
        rx_word  <= '0;
        mu       <= '0;
        mf       <= '0;
        id_rec   <= '0;
        digest   <= '0;
      end
    end
  end

  // R13: a pending request is held until the engine takes it
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (exp_req && !exp_rdy && card_present && !tok_reject && !tmo) |=> exp_req);

  // R13: requests are mutually exclusive
  p_req_excl_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exp_req, rng_req, hash_req}));

  // R10: enable only follows a cycle with the token present
  p_en_needs_card_r10: assert property (@(posedge clk) disable iff (rst)
    func_en |-> $past(card_present));

  // R6: no engine traffic while access is granted
  p_en_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    func_en |-> !(exp_req || rng_req || hash_req));

  // R7: rejection is a single-cycle pulse
  p_fail_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    auth_fail |=> !auth_fail);

  // R3: transmitted words never come back-to-back
  p_tx_single_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
endmodule

// File: tb/auth_seq_tb_top.sv
`timescale 1ns/1ps
module auth_seq_tb_top;
  localparam logic [31:0] KP = 32'h5A5A_1234;
  localparam logic [31:0] KC = 32'hC3C3_0F0F;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic card_drv = 1'b0, arm_drop = 1'b0, kill_evt = 1'b0;
  logic card_present;
  assign card_present = card_drv && !(arm_drop && kill_evt);

  logic rx_valid = 1'b0, tok_accept = 1'b0, tok_reject = 1'b0;
  logic [31:0] rx_data = '0;
  logic tx_valid, exp_req, exp_key_sel, rng_req, hash_req, func_en, auth_fail;
  logic [31:0] tx_data, exp_base, hash_msg;
  logic exp_rdy = 1'b0, exp_done = 1'b0, rng_rdy = 1'b0, rng_done = 1'b0;
  logic hash_rdy = 1'b0, hash_done = 1'b0;
  logic [31:0] exp_result = '0, rng_data = '0;
  logic [159:0] hash_digest = '0, key_root;
  logic tbl_we = 1'b0, tbl_valid = 1'b0;
  logic [1:0] tbl_idx = '0;
  logic [159:0] tbl_hash = '0;

  auth_seq dut_i (
    .clk(clk), .rst(rst), .card_present(card_present), .rx_valid(rx_valid),
    .rx_data(rx_data), .tok_accept(tok_accept), .tok_reject(tok_reject),
    .tx_valid(tx_valid), .tx_data(tx_data), .exp_req(exp_req), .exp_rdy(exp_rdy),
    .exp_key_sel(exp_key_sel), .exp_base(exp_base), .exp_done(exp_done),
    .exp_result(exp_result), .rng_req(rng_req), .rng_rdy(rng_rdy),
    .rng_done(rng_done), .rng_data(rng_data), .hash_req(hash_req),
    .hash_rdy(hash_rdy), .hash_msg(hash_msg), .hash_done(hash_done),
    .hash_digest(hash_digest), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_hash(tbl_hash), .tbl_valid(tbl_valid), .func_en(func_en),
    .key_root(key_root), .auth_fail(auth_fail)
  );

  int n_cmp = 0, n_bad = 0;
  int tx_cnt = 0, fail_seen = 0, rng_cnt = 0, exp_n = 0;
  logic [32:0] exp_log [0:63];
  logic [31:0] hash_seen = '0, nonce_val = '0;
  logic hang_hash = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic got_en, got_fail;
  logic [31:0] last_cid;

  function automatic logic [159:0] hfun(input logic [31:0] m);
    return {m, m ^ 32'hA5A5_A5A5, ~m, m + 32'h1234, {m[15:0], m[31:16]}};
  endfunction

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // exponentiation engine model: xor with the selected key
  initial forever begin
    @(negedge clk);
    if (exp_req) begin
      logic [31:0] b; logic s;
      b = exp_base; s = exp_key_sel;
      exp_log[exp_n[5:0]] = {s, b};
      exp_n++;
      exp_rdy = 1'b1;
      @(negedge clk); exp_rdy = 1'b0;
      repeat (2) @(negedge clk);
      exp_result = b ^ (s ? KC : KP);
      exp_done = 1'b1;
      @(negedge clk); exp_done = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rng_req) begin
      rng_cnt++;
      rng_rdy = 1'b1;
      @(negedge clk); rng_rdy = 1'b0;
      rng_data = nonce_val; rng_done = 1'b1;
      @(negedge clk); rng_done = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (hash_req && !hang_hash) begin
      hash_seen = hash_msg;
      hash_rdy = 1'b1;
      @(negedge clk); hash_rdy = 1'b0;
      @(negedge clk);
      hash_digest = hfun(hash_seen); hash_done = 1'b1;
      if (arm_drop) kill_evt = 1'b1;
      @(negedge clk); hash_done = 1'b0;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (auth_fail) fail_seen++;
    if (tx_valid) begin
      tx_cnt++;
      if (exp_q.size() == 0) chk("R3 unexpected tx", {128'd0, tx_data}, 160'd0 - 1);
      else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, {128'd0, tx_data}, {128'd0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic send(input logic [31:0] w);
    rx_data = w; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wait_tx(input int target);
    for (int i = 0; i < 200 && tx_cnt < target; i++) @(negedge clk);
  endtask

  task automatic wait_outcome();
    got_en = 1'b0; got_fail = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (func_en)   begin got_en = 1'b1; break; end
      if (auth_fail) begin got_fail = 1'b1; break; end
    end
  endtask

  task automatic insert_and_challenge(input logic [31:0] cu);
    int t0;
    card_drv = 1'b1;
    repeat (3) @(negedge clk);
    t0 = tx_cnt;
    exp_q.push_back((cu ^ KP) ^ KC); tag_q.push_back("R3 CF'");
    send(cu);
    wait_tx(t0 + 1);
  endtask

  task automatic run_full(input logic [31:0] id, input logic [31:0] cu,
                          input logic [31:0] nonce, input bit replay,
                          input logic [31:0] rcid);
    int t0; logic [31:0] mu;
    nonce_val = nonce;
    insert_and_challenge(cu);
    mu = cu ^ KP;
    t0 = tx_cnt;
    exp_q.push_back(nonce ^ KC); tag_q.push_back("R4 CF");
    tok_accept = 1'b1; @(negedge clk); tok_accept = 1'b0;
    wait_tx(t0 + 1);
    last_cid = replay ? rcid : ((id + mu + nonce) ^ KP);
    send(last_cid);
    wait_outcome();
  endtask

  task automatic remove();
    card_drv = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic twrite(input logic [1:0] idx, input logic [159:0] h, input logic v);
    tbl_idx = idx; tbl_hash = h; tbl_valid = v; tbl_we = 1'b1;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  initial begin
    logic [31:0] ida, idb, idc, cid1;
    int e0, f0, r0, cnt;
    ida = 32'h1357_9BDF; idb = 32'h2468_ACE0; idc = 32'h0BAD_F00D;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 func_en", {159'd0, func_en}, 160'd0);
    chk("R1 tx_valid", {159'd0, tx_valid}, 160'd0);
    chk("R1 auth_fail", {159'd0, auth_fail}, 160'd0);
    chk("R1 requests", {157'd0, exp_req, rng_req, hash_req}, 160'd0);
    send(32'hDEAD_BEEF);
    repeat (8) @(negedge clk);
    chk("R1 rx ignored in idle", exp_n, 0);

    twrite(2'd1, hfun(ida), 1'b1);
    twrite(2'd2, hfun(idb), 1'b0);

    // R2..R6 good run
    e0 = exp_n; r0 = rng_cnt;
    run_full(ida, 32'h0000_7777, 32'h4242_0001, 1'b0, '0);
    chk("R6 func_en", {159'd0, got_en}, 160'd1);
    chk("R6 key_root", key_root, hfun(ida));
    chk("R2 first exp request", {127'd0, exp_log[e0[5:0]]}, {127'd0, 1'b0, 32'h0000_7777});
    chk("R3 second exp request", {127'd0, exp_log[(e0 + 1) % 64]}, {127'd0, 1'b1, 32'h0000_7777 ^ KP});
    chk("R5 cid exp request", {127'd0, exp_log[(e0 + 3) % 64]}, {127'd0, 1'b0, last_cid});
    chk("R5 recovered id", {128'd0, hash_seen}, {128'd0, ida});
    chk("R4 one nonce", rng_cnt - r0, 1);
    // R12 write while granted is discarded
    twrite(2'd1, 160'd0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 requests quiet", {157'd0, exp_req, rng_req, hash_req}, 160'd0);
    remove();
    chk("R10 en drops on removal", {159'd0, func_en}, 160'd0);
    run_full(ida, 32'h0000_1111, 32'h0000_0F0F, 1'b0, '0);
    chk("R12 entry survived", {159'd0, got_en}, 160'd1);
    cid1 = last_cid;
    remove();

    // R8 invalid entry
    f0 = fail_seen;
    run_full(idb, 32'h0000_2222, 32'h0000_3333, 1'b0, '0);
    chk("R8 no enable", {159'd0, got_en}, 160'd0);
    chk("R8 reject", fail_seen - f0, 1);
    remove();

    // R7 unknown id
    f0 = fail_seen;
    run_full(idc, 32'h0000_4444, 32'h0000_5555, 1'b0, '0);
    repeat (2) @(negedge clk);
    chk("R7 single pulse", fail_seen - f0, 1);
    chk("R7 no enable", {159'd0, func_en}, 160'd0);
    remove();

    // R9 replayed token word with a fresh nonce
    r0 = rng_cnt;
    run_full(ida, 32'h0000_1111, 32'h0000_9999, 1'b1, cid1);
    chk("R9 fresh nonce drawn", rng_cnt - r0, 1);
    chk("R9 replay rejected", {159'd0, got_fail}, 160'd1);
    remove();

    // R10 token refusal
    f0 = fail_seen; r0 = rng_cnt;
    insert_and_challenge(32'h0000_AAAA);
    tok_reject = 1'b1; @(negedge clk); tok_reject = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 refuse pulse", fail_seen - f0, 1);
    chk("R10 refuse no nonce", rng_cnt - r0, 0);
    remove();

    // R10 withdrawal mid-run
    f0 = fail_seen; r0 = rng_cnt;
    insert_and_challenge(32'h0000_BBBB);
    card_drv = 1'b0;
    repeat (6) @(negedge clk);
    tok_accept = 1'b1; @(negedge clk); tok_accept = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 withdraw no pulse", fail_seen - f0, 0);
    chk("R10 withdraw no nonce", rng_cnt - r0, 0);

    // R11 hung hash engine
    hang_hash = 1'b1; f0 = fail_seen; cnt = 0;
    nonce_val = 32'h0000_0101;
    insert_and_challenge(32'h0000_CCCC);
    exp_q.push_back(32'h0000_0101 ^ KC); tag_q.push_back("R4 CF");
    tok_accept = 1'b1; @(negedge clk); tok_accept = 1'b0;
    wait_tx(tx_cnt + 1);
    send((ida + (32'h0000_CCCC ^ KP) + 32'h0000_0101) ^ KP);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (auth_fail) break;
      if (hash_req) cnt++;
    end
    chk("R11 timeout length", cnt, TMO);
    chk("R11 timeout reject", fail_seen - f0, 1);
    hang_hash = 1'b0;
    remove();

    // R10 withdrawal in the same cycle as hash completion
    arm_drop = 1'b1; f0 = fail_seen;
    run_full(ida, 32'h0000_DDDD, 32'h0000_0202, 1'b0, '0);
    chk("R10 collision no enable", {159'd0, got_en}, 160'd0);
    chk("R10 collision no pulse", fail_seen - f0, 0);
    remove();
    arm_drop = 1'b0;

    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule